// File: doc/BRIEF.md
# Priority Port Pin Multiplexer

This block drives a small group of device pins, by default four, and decides, pin by pin, which of three agents owns each one. The agents are a PWM channel, a signal of a routed serial peripheral interface, and plain general-purpose I/O. Ownership follows a fixed ladder. An enabled PWM channel always wins. If the PWM channel is off and the SPI route is on, the SPI signal takes the pin. Only when neither claims it does the pin act as a software-controlled GPIO bit, with its own data and direction bits.

A byte-wide register bus gives software three locations. The data register can be written, and on a read each bit shows either the stored bit or the sampled pin, chosen by that pin's direction bit. The direction register is read/write. The input register is read-only and always shows the sampled pins. Pad inputs pass through a synchroniser chain, two flops by default, before any read sees them. That chain has no reset, so the input register keeps showing pin levels while reset is held.

Top module: `pin_mux_port`

## Requirements
- R1: When `pwm_en[i]` is 1, `pad_out[i]` equals `pwm_out[i]` and `pad_oe[i]` is 1, whatever the SPI and GPIO settings are.
- R2: When `pwm_en[i]` is 0 and `spi_route_en` is 1, `pad_out[i]` equals `spi_out[i]` and `pad_oe[i]` equals `spi_oe[i]`.
- R3: When `pwm_en[i]` is 0 and `spi_route_en` is 0, `pad_out[i]` equals data register bit i and `pad_oe[i]` equals direction register bit i.
- R4: Pin i is tied to PWM channel i. On the SPI vectors, bit 3 carries slave select, bit 2 the serial clock, bit 1 master-out and bit 0 master-in. Each pin is resolved independently of the others.
- R5: A read of address 0x00 (data) returns, for each pin bit whose direction bit is 1, the stored data bit, and for a pin bit whose direction bit is 0, the synchronised pad level. Bits 7..4 read 0.
- R6: A read of address 0x02 (input) returns the synchronised pad levels whatever owns the pins. A write to 0x02 changes neither the data register nor the direction register.
- R7: After reset the data and direction registers are 0. A read of 0x01 returns 0, and with no alternate function enabled every `pad_oe` is 0.
- R8: A change on `pad_in` becomes visible in reads exactly two rising clock edges later. It is not visible after one edge.
- R9: A write with `bus_we` high at a rising edge to 0x00 or 0x01 updates the low four bits of that register at that edge. With `bus_we` low, nothing changes.
- R10: Reads of any address other than 0x00, 0x01 and 0x02 return 0.
- R11: The synchroniser has no reset: while `rst_n` is low, a read of 0x02 still returns the pad levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the data and direction registers |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| pwm_en | input | 4 | Per-channel PWM enable |
| pwm_out | input | 4 | PWM channel outputs |
| spi_route_en | input | 1 | Routed SPI enable |
| spi_out | input | 4 | SPI signal outputs: [3] SS, [2] SCK, [1] MOSI, [0] MISO |
| spi_oe | input | 4 | SPI per-signal output enables, same bit order |
| pad_in | input | 4 | Pad input levels |
| pad_out | output | 4 | Pad output levels |
| pad_oe | output | 4 | Pad output enables |

## Verification
The pin-ownership outputs are combinational. The bench therefore drives the owner inputs just after a falling edge and checks `pad_out` and `pad_oe` in the same half cycle. A register write is launched after a falling edge, takes effect at the next rising edge, and is read back after the falling edge that follows. Pad input changes are due two rising edges after they are driven. The bench checks the input register after one edge, expecting the old value, and again after the second edge, expecting the new one. All reads are combinational, so each read is sampled a short delay after the address is set, away from any clock edge.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
   typedef enum logic [1:0] {
      OWNER_GPIO = 2'd0,
      OWNER_SPI  = 2'd1,
      OWNER_PWM  = 2'd2
   } owner_e;

   // Fixed ladder: PWM above SPI above GPIO
   function automatic owner_e resolve_owner(input logic pwm_on, input logic spi_on);
      if (pwm_on)      return OWNER_PWM;
      else if (spi_on) return OWNER_SPI;
      else             return OWNER_GPIO;
   endfunction
endpackage

// File: rtl/pmx_sync.sv
module pmx_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   // No reset: the buffered pin state is not disturbed by reset
   always_ff @(posedge clk) begin
      chain[0] <= d;
      for (int k = 1; k < STAGES; k++) begin
         chain[k] <= chain[k-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pmx_regs.sv
module pmx_regs #(
   parameter int          NUM_PINS  = 4,
   parameter int          ADDR_W    = 8,
   parameter int          DATA_W    = 8,
   parameter logic [7:0]  ADDR_DATA = 8'h00,
   parameter logic [7:0]  ADDR_DIR  = 8'h01,
   parameter logic [7:0]  ADDR_IN   = 8'h02
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   wdata,
   input  logic [NUM_PINS-1:0] pin_sync,
   output logic [NUM_PINS-1:0] data_q,
   output logic [NUM_PINS-1:0] dir_q,
   output logic [DATA_W-1:0]   rdata
);
   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(ADDR_DATA);
   localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(ADDR_DIR);
   localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(ADDR_IN);

   logic [NUM_PINS-1:0] wlo;
   assign wlo = wdata[NUM_PINS-1:0];

   generate
      if (DATA_W > NUM_PINS) begin : g_spare
         logic wdata_hi_unused;
         assign wdata_hi_unused = ^wdata[DATA_W-1:NUM_PINS];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         dir_q  <= '0;
      end else if (we) begin
         if (addr == A_DATA) data_q <= wlo;
         if (addr == A_DIR)  dir_q  <= wlo;
      end
   end

   always_comb begin
      rdata = '0;
      unique case (addr)
         A_DATA:  rdata[NUM_PINS-1:0] = (dir_q & data_q) | (~dir_q & pin_sync);
         A_DIR:   rdata[NUM_PINS-1:0] = dir_q;
         A_IN:    rdata[NUM_PINS-1:0] = pin_sync;
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/pmx_pin_sel.sv
module pmx_pin_sel
   import pmx_pkg::*;
#(
   parameter int NUM_PINS = 4
) (
   input  logic [NUM_PINS-1:0] pwm_en,
   input  logic [NUM_PINS-1:0] pwm_out,
   input  logic                spi_route_en,
   input  logic [NUM_PINS-1:0] spi_out,
   input  logic [NUM_PINS-1:0] spi_oe,
   input  logic [NUM_PINS-1:0] gpio_data,
   input  logic [NUM_PINS-1:0] gpio_dir,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe
);
   generate
      for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
         owner_e own;
         assign own = resolve_owner(pwm_en[p], spi_route_en);
         always_comb begin
            unique case (own)
               OWNER_PWM: begin pad_out[p] = pwm_out[p];   pad_oe[p] = 1'b1;       end
               OWNER_SPI: begin pad_out[p] = spi_out[p];   pad_oe[p] = spi_oe[p];  end
               default:   begin pad_out[p] = gpio_data[p]; pad_oe[p] = gpio_dir[p]; end
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/pin_mux_port.sv
module pin_mux_port #(
   parameter int          NUM_PINS    = 4,
   parameter int          ADDR_W      = 8,
   parameter int          DATA_W      = 8,
   parameter int          SYNC_STAGES = 2,
   parameter logic [7:0]  ADDR_DATA   = 8'h00,
   parameter logic [7:0]  ADDR_DIR    = 8'h01,
   parameter logic [7:0]  ADDR_IN     = 8'h02
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [NUM_PINS-1:0] pwm_en,
   input  logic [NUM_PINS-1:0] pwm_out,
   input  logic                spi_route_en,
   input  logic [NUM_PINS-1:0] spi_out,
   input  logic [NUM_PINS-1:0] spi_oe,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe
);
   generate
      if (NUM_PINS < 1 || NUM_PINS > DATA_W) begin : g_bad_pins
         $error("pin_mux_port: NUM_PINS must lie in 1..DATA_W");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("pin_mux_port: SYNC_STAGES must be at least 2");
      end
      if (ADDR_W > 8) begin : g_bad_addr
         $error("pin_mux_port: ADDR_W must not exceed 8");
      end
   endgenerate

   logic [NUM_PINS-1:0] pin_sync;
   logic [NUM_PINS-1:0] data_reg;
   logic [NUM_PINS-1:0] dir_reg;

   pmx_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .d   (pad_in),
      .q   (pin_sync)
   );

   pmx_regs #(
      .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .ADDR_DATA(ADDR_DATA), .ADDR_DIR(ADDR_DIR), .ADDR_IN(ADDR_IN)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (bus_we),
      .addr     (bus_addr),
      .wdata    (bus_wdata),
      .pin_sync (pin_sync),
      .data_q   (data_reg),
      .dir_q    (dir_reg),
      .rdata    (bus_rdata)
   );

   pmx_pin_sel #(.NUM_PINS(NUM_PINS)) u_sel (
      .pwm_en       (pwm_en),
      .pwm_out      (pwm_out),
      .spi_route_en (spi_route_en),
      .spi_out      (spi_out),
      .spi_oe       (spi_oe),
      .gpio_data    (data_reg),
      .gpio_dir     (dir_reg),
      .pad_out      (pad_out),
      .pad_oe       (pad_oe)
   );
endmodule

// File: rtl/pmx_checker.sv
module pmx_checker #(
   parameter int          NUM_PINS    = 4,
   parameter int          ADDR_W      = 8,
   parameter int          DATA_W      = 8,
   parameter int          SYNC_STAGES = 2,
   parameter logic [7:0]  ADDR_DATA   = 8'h00,
   parameter logic [7:0]  ADDR_DIR    = 8'h01,
   parameter logic [7:0]  ADDR_IN     = 8'h02
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_we,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [NUM_PINS-1:0] wdata_lo,
   input logic [DATA_W-1:0]   bus_rdata,
   input logic [NUM_PINS-1:0] pwm_en,
   input logic [NUM_PINS-1:0] pwm_out,
   input logic                spi_route_en,
   input logic [NUM_PINS-1:0] spi_out,
   input logic [NUM_PINS-1:0] spi_oe,
   input logic [NUM_PINS-1:0] pad_in,
   input logic [NUM_PINS-1:0] pad_out,
   input logic [NUM_PINS-1:0] pad_oe,
   input logic [NUM_PINS-1:0] data_reg,
   input logic [NUM_PINS-1:0] dir_reg
);
   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(ADDR_DATA);
   localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(ADDR_DIR);
   localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(ADDR_IN);

   generate
      for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin_chk
         a_r1_pwm_owns: assert property (@(posedge clk) disable iff (!rst_n)
            pwm_en[p] |-> (pad_oe[p] && pad_out[p] == pwm_out[p]));
         a_r2_spi_owns: assert property (@(posedge clk) disable iff (!rst_n)
            (!pwm_en[p] && spi_route_en) |-> (pad_out[p] == spi_out[p] && pad_oe[p] == spi_oe[p]));
         a_r3_gpio_owns: assert property (@(posedge clk) disable iff (!rst_n)
            (!pwm_en[p] && !spi_route_en) |-> (pad_out[p] == data_reg[p] && pad_oe[p] == dir_reg[p]));
      end
      if (SYNC_STAGES == 2) begin : g_lat_chk
         a_r8_two_edge_input: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_addr == A_IN) |-> (bus_rdata[NUM_PINS-1:0] == $past(pad_in, 2)));
      end
   endgenerate

   a_r6_input_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_IN) |=> ($stable(data_reg) && $stable(dir_reg)));

   a_r9_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_DIR) |=> (dir_reg == $past(wdata_lo)));

   a_r9_data_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_DATA) |=> (data_reg == $past(wdata_lo)));

   a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr != A_DATA && bus_addr != A_DIR && bus_addr != A_IN) |-> (bus_rdata == '0));
endmodule

bind pin_mux_port pmx_checker #(
   .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES),
   .ADDR_DATA(ADDR_DATA), .ADDR_DIR(ADDR_DIR), .ADDR_IN(ADDR_IN)
) u_pmx_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_we       (bus_we),
   .bus_addr     (bus_addr),
   .wdata_lo     (bus_wdata[NUM_PINS-1:0]),
   .bus_rdata    (bus_rdata),
   .pwm_en       (pwm_en),
   .pwm_out      (pwm_out),
   .spi_route_en (spi_route_en),
   .spi_out      (spi_out),
   .spi_oe       (spi_oe),
   .pad_in       (pad_in),
   .pad_out      (pad_out),
   .pad_oe       (pad_oe),
   .data_reg     (data_reg),
   .dir_reg      (dir_reg)
);

// File: tb/pin_mux_port_bench.sv
module pin_mux_port_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_addr = 8'h00;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic [3:0] pwm_en = 4'h0, pwm_out = 4'h0;
   logic       spi_route_en = 1'b0;
   logic [3:0] spi_out = 4'h0, spi_oe = 4'h0;
   logic [3:0] pad_in = 4'b1011;
   logic [3:0] pad_out, pad_oe;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   pin_mux_port u_pin_mux_port (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_en(pwm_en),
      .pwm_out(pwm_out), .spi_route_en(spi_route_en), .spi_out(spi_out),
      .spi_oe(spi_oe), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
   );

   typedef struct packed {
      logic [3:0] en, pwm;
      logic       route;
      logic [3:0] so, soe, data, dir, exp_out, exp_oe;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VECS [NV] = '{
      '{4'b0000, 4'b1111, 1'b0, 4'b1111, 4'b1111, 4'b1010, 4'b1100, 4'b1010, 4'b1100},
      '{4'b1111, 4'b0101, 1'b1, 4'b1010, 4'b0000, 4'b1111, 4'b0000, 4'b0101, 4'b1111},
      '{4'b0000, 4'b0000, 1'b1, 4'b1001, 4'b1110, 4'b0110, 4'b1111, 4'b1001, 4'b1110},
      '{4'b1010, 4'b1000, 1'b1, 4'b0111, 4'b0101, 4'b0000, 4'b0000, 4'b1101, 4'b1111},
      '{4'b0100, 4'b0100, 1'b0, 4'b0000, 4'b0000, 4'b1001, 4'b0011, 4'b1101, 4'b0111},
      '{4'b0001, 4'b0000, 1'b1, 4'b1111, 4'b1000, 4'b0000, 4'b1111, 4'b1110, 4'b1001}
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] rd;
      // R11: pads read through while reset is held
      repeat (4) @(negedge clk);
      bus_read(8'h02, rd);
      check("R11 input visible in reset", rd, 8'h0B);
      rst_n = 1'b1;
      @(negedge clk);

      // R7: reset state
      bus_read(8'h01, rd);
      check("R7 dir reset", rd, 8'h00);
      check("R7 oe reset", {4'h0, pad_oe}, 8'h00);
      bus_read(8'h00, rd);
      check("R7 data reads pad when dir 0", rd, 8'h0B);

      // Table: R1 R2 R3 R4 ownership ladder and pin mapping
      for (int v = 0; v < NV; v++) begin
         bus_write(8'h01, {4'h0, VECS[v].dir});
         bus_write(8'h00, {4'h0, VECS[v].data});
         pwm_en = VECS[v].en; pwm_out = VECS[v].pwm;
         spi_route_en = VECS[v].route; spi_out = VECS[v].so; spi_oe = VECS[v].soe;
         #0.5;
         check($sformatf("R1 R2 R3 R4 vec %0d out", v), {4'h0, pad_out}, {4'h0, VECS[v].exp_out});
         check($sformatf("R1 R2 R3 R4 vec %0d oe", v),  {4'h0, pad_oe},  {4'h0, VECS[v].exp_oe});
      end

      // R9: writes land at the edge; no write when strobe low
      bus_write(8'h01, 8'hF5);
      bus_read(8'h01, rd);
      check("R9 dir write", rd, 8'h05);
      @(negedge clk);
      bus_we = 1'b0; bus_addr = 8'h01; bus_wdata = 8'h0A;
      @(negedge clk);
      bus_read(8'h01, rd);
      check("R9 no write without strobe", rd, 8'h05);

      // R5: data read source follows direction bit
      bus_write(8'h00, 8'h0F);
      pad_in = 4'b0000;
      repeat (2) @(negedge clk);
      bus_read(8'h00, rd);
      check("R5 mixed read pad low", rd, 8'h05);
      pad_in = 4'b1010;
      repeat (2) @(negedge clk);
      bus_read(8'h00, rd);
      check("R5 mixed read pad high", rd, 8'h0F);

      // R8: two-edge latency
      @(negedge clk);
      pad_in = 4'b0110;
      @(negedge clk);
      bus_read(8'h02, rd);
      check("R8 not visible after one edge", rd, 8'h0A);
      @(negedge clk);
      bus_read(8'h02, rd);
      check("R8 visible after two edges", rd, 8'h06);

      // R6: input reg independent of owner; writes ignored
      pwm_en = 4'hF; pwm_out = 4'h9;
      bus_read(8'h02, rd);
      check("R6 input under pwm owner", rd, 8'h06);
      bus_write(8'h02, 8'hFF);
      bus_read(8'h01, rd);
      check("R6 dir unchanged by input write", rd, 8'h05);
      pwm_en = 4'h0; spi_route_en = 1'b0;
      #0.5;
      check("R6 data unchanged by input write", {4'h0, pad_out}, 8'h0F);

      // R10: unmapped addresses
      bus_read(8'h03, rd);
      check("R10 addr 03", rd, 8'h00);
      bus_read(8'h80, rd);
      check("R10 addr 80", rd, 8'h00);
      bus_read(8'hFF, rd);
      check("R10 addr FF", rd, 8'h00);

      finish_run();
   end
endmodule